// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is a small parallel I/O port of sixteen pins sitting behind a simple synchronous register bus. Each pin has one bit in four per-pin registers: a latched level, a direction bit, an input-gate bit and a function-gate bit. A level arriving on a pin is copied into the latched level only when that pin is an input and both of its gate bits are open. Software can change the latched level and the direction bits through plain writes. It can also use dedicated aliases that OR ones in or knock ones out, so no read-modify-write sequence is needed.

The outward pin levels are refreshed only when software writes to one of the level addresses or to the direction OR-alias. On such a write, every pin whose input-gate bit is low takes its freshly latched level. A 32-bit mux word is also stored for the pad selection logic that sits next to the port. Every access is size-checked. A wrong size or an unknown offset gives a one-cycle error code and leaves all state untouched.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset every register reads 0, `pin_out` is 0 and `pin_dir` is 0 (all pins are inputs).
- R2: Register offsets are: level 0x00, level-OR 0x04, level-clear 0x08, direction 0x0C, direction-OR 0x10, direction-clear 0x14, input gate 0x18, function gate 0x1C, mux 0x20. Read data appears on `bus_rdata` in the cycle after the request. Both aliases of a register read back that register.
- R3: A write to the level-OR offset sets every level bit where the written value holds a 1 and leaves the other bits alone.
- R4: A write to the level-clear offset clears every level bit where the written value holds a 1 and leaves the other bits alone.
- R5: The direction register takes plain writes, OR writes and clear writes in the same way as the level register. Its value appears on `pin_dir`, where 1 means output.
- R6: A pin's incoming level is copied into the level register only while its direction bit is 0, its input-gate bit is 1 and its function-gate bit is 1. Otherwise that level bit holds its value.
- R7: Each pin's incoming level is an `LVL_W`-bit field, and any nonzero value is taken as logic 1.
- R8: After a write to the level, level-OR, level-clear or direction-OR offset, each pin whose input-gate bit is 0 drives its updated level bit on `pin_out`. Pins whose gate bit is 1 keep their output. Any other access leaves `pin_out` unchanged.
- R9: `bus_err` shows, in the cycle after a request, 2'b01 for a wrong size (the mux word needs 4 bytes, every other offset needs 2), 2'b10 for an unmapped offset of legal size, and 2'b00 otherwise. A wrong size takes priority over an unmapped offset.
- R10: A request that raises an error changes no register and no output, and a failed read returns 0.
- R11: The mux word stores and returns all 32 bits and does not affect the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | MUX_W | Write data |
| bus_rdata | output | MUX_W | Read data, valid the cycle after the request |
| bus_err | output | 2 | Error code, valid the cycle after the request |
| pin_level | input | PINS*LVL_W | Incoming level per pin, LVL_W bits each |
| pin_out | output | PINS | Driven pin levels |
| pin_dir | output | PINS | Per-pin direction, 1 = output |

## Verification
The assertions assume that `bus_req` is a single-cycle strobe and that `bus_addr`, `bus_size` and `bus_wdata` hold defined values whenever it is high. The bench drives every request for exactly one cycle from the falling clock edge and drops it afterwards. The rule that gated pins hold their level is checked only in cycles with no write, because a write may legally replace any bit. The bench changes pin levels only between accesses and waits two cycles before reading, so each sample it checks has settled.

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int PINS   = 16,
  parameter int LVL_W  = 2,
  parameter int MUX_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [2:0]              bus_size,
  input  logic [MUX_W-1:0]        bus_wdata,
  output logic [MUX_W-1:0]        bus_rdata,
  output logic [1:0]              bus_err,
  input  logic [PINS*LVL_W-1:0]   pin_level,
  output logic [PINS-1:0]         pin_out,
  output logic [PINS-1:0]         pin_dir
);

  localparam logic [ADDR_W-1:0] OFF_LVL  = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] OFF_LSET = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] OFF_LCLR = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] OFF_DSET = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] OFF_DCLR = ADDR_W'(6'h14);
  localparam logic [ADDR_W-1:0] OFF_IGT  = ADDR_W'(6'h18);
  localparam logic [ADDR_W-1:0] OFF_FGT  = ADDR_W'(6'h1C);
  localparam logic [ADDR_W-1:0] OFF_MUX  = ADDR_W'(6'h20);
  localparam logic [2:0] SZ_REG = 3'd2;
  localparam logic [2:0] SZ_MUX = 3'd4;
  localparam logic [1:0] E_NONE = 2'b00;
  localparam logic [1:0] E_SIZE = 2'b01;
  localparam logic [1:0] E_ADDR = 2'b10;

  logic [PINS-1:0]  lvl_q, dir_q, igt_q, fgt_q, out_q;
  logic [MUX_W-1:0] mux_q, rdata_q;
  logic [1:0]       err_q;
  logic [PINS-1:0]  lvl_in, accept, lvl_nxt, dir_nxt;
  logic [MUX_W-1:0] rsel;

  for (genvar i = 0; i < PINS; i++) begin : g_lvl
    assign lvl_in[i] = |pin_level[i*LVL_W +: LVL_W];
  end

  wire h_lvl  = bus_addr == OFF_LVL;
  wire h_lset = bus_addr == OFF_LSET;
  wire h_lclr = bus_addr == OFF_LCLR;
  wire h_dir  = bus_addr == OFF_DIR;
  wire h_dset = bus_addr == OFF_DSET;
  wire h_dclr = bus_addr == OFF_DCLR;
  wire h_igt  = bus_addr == OFF_IGT;
  wire h_fgt  = bus_addr == OFF_FGT;
  wire h_mux  = bus_addr == OFF_MUX;

  wire mapped   = h_lvl | h_lset | h_lclr | h_dir | h_dset | h_dclr | h_igt | h_fgt | h_mux;
  wire size_bad = h_mux ? (bus_size != SZ_MUX) : (bus_size != SZ_REG);
  wire acc_ok   = bus_req && !size_bad && mapped;
  wire wr       = acc_ok && bus_we;
  wire rd       = acc_ok && !bus_we;
  wire [PINS-1:0] wv = bus_wdata[PINS-1:0];
  wire lvl_wr   = wr && (h_lvl | h_lset | h_lclr);
  wire drive    = lvl_wr || (wr && h_dset);

  assign accept = ~dir_q & igt_q & fgt_q;

  always_comb begin
    lvl_nxt = (lvl_q & ~accept) | (lvl_in & accept);
    if (wr && h_lvl)       lvl_nxt = wv;
    else if (wr && h_lset) lvl_nxt = lvl_q | wv;
    else if (wr && h_lclr) lvl_nxt = lvl_q & ~wv;
  end

  always_comb begin
    dir_nxt = dir_q;
    if (wr && h_dir)       dir_nxt = wv;
    else if (wr && h_dset) dir_nxt = dir_q | wv;
    else if (wr && h_dclr) dir_nxt = dir_q & ~wv;
  end

  always_comb begin
    rsel = '0;
    if (h_lvl | h_lset | h_lclr) rsel = MUX_W'(lvl_q);
    else if (h_dir | h_dset | h_dclr) rsel = MUX_W'(dir_q);
    else if (h_igt) rsel = MUX_W'(igt_q);
    else if (h_fgt) rsel = MUX_W'(fgt_q);
    else if (h_mux) rsel = mux_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      dir_q   <= '0;
      igt_q   <= '0;
      fgt_q   <= '0;
      out_q   <= '0;
      mux_q   <= '0;
      rdata_q <= '0;
      err_q   <= E_NONE;
    end else begin
      lvl_q <= lvl_nxt;
      dir_q <= dir_nxt;
      if (wr && h_igt) igt_q <= wv;
      if (wr && h_fgt) fgt_q <= wv;
      if (wr && h_mux) mux_q <= bus_wdata;
      if (drive) out_q <= (out_q & igt_q) | (lvl_nxt & ~igt_q);
      rdata_q <= rd ? rsel : '0;
      err_q   <= !bus_req ? E_NONE : size_bad ? E_SIZE : !mapped ? E_ADDR : E_NONE;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign pin_out   = out_q;
  assign pin_dir   = dir_q;

  // R6: with no write, bits that were not accepting input keep their value
  p_gated_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we) |=> ((lvl_q ^ $past(lvl_q)) & ~$past(accept)) == '0);

  // R3
  p_or_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && h_lset) |=> (lvl_q & $past(wv)) == $past(wv));

  // R4
  p_clr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && h_lclr) |=> (lvl_q & $past(wv)) == '0);

  // R8: outputs move only after a driving write
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |=> $stable(pin_out));

  // R8: gated-input pins keep their driven value even on a driving write
  p_out_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive |=> ((pin_out ^ $past(pin_out)) & $past(igt_q)) == '0);

  // R10
  p_err_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (size_bad || !mapped)) |=>
      $stable(dir_q) && $stable(igt_q) && $stable(fgt_q) && $stable(mux_q) && $stable(pin_out)
      && bus_rdata == '0 && bus_err != E_NONE);

  // R9
  p_err_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_err));

endmodule

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb;
  localparam int PINS = 16, LVL_W = 2, MUX_W = 32, ADDR_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [2:0] bus_size = '0;
  logic [MUX_W-1:0] bus_wdata = '0, bus_rdata;
  logic [1:0] bus_err;
  logic [PINS*LVL_W-1:0] pin_level = '0;
  logic [PINS-1:0] pin_out, pin_dir;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gpio_setclr_port #(.PINS(PINS), .LVL_W(LVL_W), .MUX_W(MUX_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pin_level(pin_level), .pin_out(pin_out), .pin_dir(pin_dir));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [2:0] s, logic [31:0] d, output logic [1:0] e);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    e = bus_err;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [2:0] s, output logic [31:0] d, output logic [1:0] e);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = s;
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_req = 1'b0;
  endtask

  task automatic w2(logic [5:0] a, logic [31:0] d);
    logic [1:0] e;
    wr(a, 3'd2, d, e);
  endtask

  task automatic r2(logic [5:0] a, output logic [31:0] d);
    logic [1:0] e;
    rd(a, 3'd2, d, e);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; pin_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [1:0] e;
    do_reset();
    for (int a = 0; a <= 'h1C; a += 4) begin
      rd(6'(a), 3'd2, d, e);
      chk("R1 reg", d, 0);
    end
    rd(6'h20, 3'd4, d, e);
    chk("R1 mux", d, 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pin_dir", 32'(pin_dir), 0);
  endtask

  task automatic t_set_clr;
    logic [31:0] d;
    do_reset();
    w2(6'h00, 32'h1200);
    w2(6'h04, 32'h0034);
    r2(6'h00, d); chk("R3 or-alias", d, 32'h1234);
    w2(6'h08, 32'h1004);
    r2(6'h00, d); chk("R4 clear-alias", d, 32'h0230);
    r2(6'h04, d); chk("R2 alias readback", d, 32'h0230);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    do_reset();
    w2(6'h0C, 32'h00F0);
    w2(6'h10, 32'h0F01);
    r2(6'h0C, d); chk("R5 dir or", d, 32'h0FF1);
    w2(6'h14, 32'h00F0);
    r2(6'h14, d); chk("R5 dir clear", d, 32'h0F01);
    chk("R5 pin_dir", 32'(pin_dir), 32'h0F01);
  endtask

  task automatic t_gating;
    logic [31:0] d;
    do_reset();
    w2(6'h0C, 32'h000F);
    w2(6'h18, 32'h00FF);
    w2(6'h1C, 32'hFFFF);
    w2(6'h00, 32'hFF0F);
    pin_level = {PINS{2'b01}};
    repeat (2) @(negedge clk);
    r2(6'h00, d); chk("R6 only open pins sample", d, 32'hFFFF);
    pin_level = '0;
    repeat (2) @(negedge clk);
    r2(6'h00, d); chk("R6 gated pins hold", d, 32'hFF0F);
    w2(6'h1C, 32'hFF0F);
    pin_level = {PINS{2'b01}};
    repeat (2) @(negedge clk);
    r2(6'h00, d); chk("R6 function gate closes", d, 32'hFF0F);
  endtask

  task automatic t_level;
    logic [31:0] d;
    do_reset();
    w2(6'h18, 32'hFFFF);
    w2(6'h1C, 32'hFFFF);
    pin_level = '0;
    pin_level[4*LVL_W +: LVL_W] = 2'b10;
    pin_level[5*LVL_W +: LVL_W] = 2'b11;
    pin_level[6*LVL_W +: LVL_W] = 2'b01;
    repeat (2) @(negedge clk);
    r2(6'h00, d); chk("R7 nonzero is one", d, 32'h0070);
  endtask

  task automatic t_drive;
    logic [31:0] d;
    do_reset();
    w2(6'h00, 32'h1234);
    chk("R8 level write drives", 32'(pin_out), 32'h1234);
    w2(6'h18, 32'h00FF);
    chk("R8 gate write no drive", 32'(pin_out), 32'h1234);
    w2(6'h00, 32'hFFFF);
    chk("R8 gated pins keep", 32'(pin_out), 32'hFF34);
    w2(6'h18, 32'hFFFF);
    w2(6'h1C, 32'hFFFF);
    pin_level = '0;
    repeat (2) @(negedge clk);
    w2(6'h18, 32'h0000);
    r2(6'h00, d); chk("R6 sampled low", d, 32'h0000);
    w2(6'h14, 32'h0000);
    chk("R8 dir-clear no drive", 32'(pin_out), 32'hFF34);
    w2(6'h0C, 32'h0000);
    chk("R8 dir write no drive", 32'(pin_out), 32'hFF34);
    w2(6'h10, 32'h0000);
    chk("R8 dir-or drives", 32'(pin_out), 32'h0000);
  endtask

  task automatic t_errors;
    logic [31:0] d; logic [1:0] e;
    do_reset();
    w2(6'h18, 32'h00AA);
    wr(6'h18, 3'd4, 32'h0055, e); chk("R9 size err", 32'(e), 1);
    r2(6'h18, d); chk("R10 no change", d, 32'h00AA);
    wr(6'h24, 3'd2, 32'h1, e); chk("R9 addr err", 32'(e), 2);
    wr(6'h24, 3'd1, 32'h1, e); chk("R9 size wins", 32'(e), 1);
    wr(6'h02, 3'd2, 32'hFFFF, e); chk("R9 unaligned", 32'(e), 2);
    chk("R10 pins still", 32'(pin_out), 0);
    rd(6'h20, 3'd2, d, e); chk("R9 mux size", 32'(e), 1);
    chk("R10 read zero", d, 0);
    wr(6'h00, 3'd4, 32'hFFFF, e); chk("R10 level size err", 32'(e), 1);
    chk("R10 pin_out", 32'(pin_out), 0);
    wr(6'h20, 3'd4, 32'h1, e); chk("R9 good access", 32'(e), 0);
  endtask

  task automatic t_mux;
    logic [31:0] d; logic [1:0] e;
    do_reset();
    wr(6'h20, 3'd4, 32'hDEADBEEF, e);
    rd(6'h20, 3'd4, d, e); chk("R11 mux word", d, 32'hDEADBEEF);
    chk("R11 pins untouched", 32'(pin_out), 0);
    r2(6'h00, d); chk("R11 level untouched", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_set_clr();
    t_dir();
    t_gating();
    t_level();
    t_drive();
    t_errors();
    t_mux();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule